// File: doc/BRIEF.md
# Scan Self-Test Shift/Capture Sequencer

This block runs a built-in self-test on a circuit whose flops are stitched into one scan chain. Once started, it feeds the chain one pseudo-random bit per clock from an internal linear feedback shift register (the pattern generator). When a whole pattern sits in the chain, it drops scan-enable for one clock and raises a capture strobe, so the circuit under test loads its response into the same flops. The next pattern then goes in while the captured response comes out of the chain's far end. Each bit that comes out is folded into a serial-input signature register.

After the last capture, the sequencer spends one more chain length shifting zeros in to flush the final response into the signature. It then raises done and holds the signature steady until the next start. The generator and the signature register are reloaded with their seeds at every start, so a repeated run on a fault-free circuit gives the same signature. That signature is compared against a known-good value outside this block.

Top module: `bist_scan_seq`

## Requirements
- R1: While reset is low and after reset, scan_en, capture, scan_in and done are 0 and signature equals SIG_SEED.
- R2: A start seen high at a clock edge while idle begins a run. From the next cycle scan_en is 1 and done is 0. The generator is reloaded with GEN_SEED and the signature with SIG_SEED.
- R3: The generator state G starts at GEN_SEED. In each pattern-shift cycle, scan_in equals G[GEN_W-1]. At that cycle's edge, G becomes {G[GEN_W-2:0], ^(G & GEN_TAPS)}. G does not change in any other cycle.
- R4: Each pattern takes exactly CHAIN_LEN consecutive cycles with scan_en = 1. These are followed by exactly one cycle with capture = 1 and scan_en = 0. A run contains exactly NUM_PAT capture cycles.
- R5: At a cycle's edge, the signature register S absorbs scan_out as S <= {S[SIG_W-2:0], ^(S & SIG_TAPS) ^ scan_out}. This happens in every scan_en cycle except those of the first pattern, where scan_out is ignored and S holds.
- R6: After the last capture come CHAIN_LEN further cycles with scan_en = 1 and scan_in = 0, during which the generator does not advance.
- R7: Done rises in the cycle after the last flush shift. From then on, done stays 1, scan_en and capture stay 0, and signature stays unchanged until the next start.
- R8: A start pulse while a run is in progress is ignored: the run's timing, its scan_in stream and its final signature are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a self-test run when idle |
| scan_in | output | 1 | Serial bit into the scan chain head |
| scan_en | output | 1 | Scan chain shift enable |
| capture | output | 1 | One-cycle strobe loading the response into the chain |
| scan_out | input | 1 | Serial bit from the scan chain tail |
| signature | output | SIG_W | Compacted response signature |
| done | output | 1 | Run finished; signature final |

## Verification
The bench builds the block with an 8-flop chain, five patterns, an 8-bit generator and a 16-bit signature register. At that size a full run is 53 cycles, so every cycle of every run can be compared against a model. The circuit-under-test model rotates the chain and XORs in a key, and the sweep covers 18 key values, each of which gives a different signature. One run carries a start pulse in the middle of a pattern, and the runs follow each other back to back, so reseeding and the stability of done are exercised between them.

// File: rtl/bist_seq_pkg.sv
// Shared types for the scan self-test sequencer.
package bist_seq_pkg;
    // Sequencer phases.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_FLUSH   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/bist_prpg.sv
// Pattern generator: a left-shifting Fibonacci LFSR whose MSB is the serial output.
// Assumes: GEN_SEED is nonzero and GEN_TAPS selects the feedback positions.
module bist_prpg #(
    parameter int          GEN_W    = 8,
    parameter logic [GEN_W-1:0] GEN_TAPS = 8'hB8,
    parameter logic [GEN_W-1:0] GEN_SEED = 8'h5A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic serial_bit
);
    logic [GEN_W-1:0] gen_q;
    logic             fb;

    // Feedback bit from the tapped positions.
    always_comb fb = ^(gen_q & GEN_TAPS);

    // Reseed on load, advance on step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n || load) gen_q <= GEN_SEED;
        else if (step)      gen_q <= {gen_q[GEN_W-2:0], fb};
    end

    assign serial_bit = gen_q[GEN_W-1];
endmodule

// File: rtl/bist_sisr.sv
// Serial-input signature register: an LFSR whose feedback is XORed with the input bit.
// Assumes: absorb is raised only in cycles whose sdi value belongs to a captured response.
module bist_sisr #(
    parameter int               SIG_W    = 16,
    parameter logic [SIG_W-1:0] SIG_TAPS = 16'hB400,
    parameter logic [SIG_W-1:0] SIG_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             absorb,
    input  logic             sdi,
    output logic [SIG_W-1:0] sig
);
    logic [SIG_W-1:0] sig_q;
    logic             fb;

    // Tap parity mixed with the incoming response bit.
    always_comb fb = (^(sig_q & SIG_TAPS)) ^ sdi;

    // Reseed on clear, compact on absorb, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) sig_q <= SIG_SEED;
        else if (absorb)     sig_q <= {sig_q[SIG_W-2:0], fb};
    end

    assign sig = sig_q;
endmodule

// File: rtl/bist_seq_ctrl.sv
// Sequencer FSM: idle -> (shift, capture) x NUM_PAT -> flush -> idle with done.
// Assumes: start is synchronous; it is honoured only in the idle phase.
module bist_seq_ctrl
    import bist_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int NUM_PAT   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output seq_state_e state,
    output logic       gen_load,
    output logic       gen_step,
    output logic       sig_clear,
    output logic       sig_absorb,
    output logic       done
);
    localparam int BIT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam int PAT_W = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAIN_LEN - 1);
    localparam logic [PAT_W-1:0] LAST_PAT = PAT_W'(NUM_PAT - 1);

    seq_state_e       st_q;
    logic [BIT_W-1:0] bit_cnt;
    logic [PAT_W-1:0] pat_cnt;
    logic             done_q;

    // Phase sequencing with bit and pattern counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            bit_cnt <= '0;
            pat_cnt <= '0;
            done_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q    <= ST_SHIFT;
                        bit_cnt <= '0;
                        pat_cnt <= '0;
                        done_q  <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        st_q    <= ST_CAPTURE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_CAPTURE: begin
                    if (pat_cnt == LAST_PAT) begin
                        st_q <= ST_FLUSH;
                    end else begin
                        pat_cnt <= pat_cnt + 1'b1;
                        st_q    <= ST_SHIFT;
                    end
                end
                ST_FLUSH: begin
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        st_q    <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Enables for generator and compactor decoded from the current phase.
    always_comb begin
        gen_load   = (st_q == ST_IDLE) && start;
        sig_clear  = (st_q == ST_IDLE) && start;
        gen_step   = (st_q == ST_SHIFT);
        sig_absorb = ((st_q == ST_SHIFT) && (pat_cnt != '0)) || (st_q == ST_FLUSH);
    end

    assign state = st_q;
    assign done  = done_q;
endmodule

// File: rtl/bist_scan_seq.sv
// Top: drives one scan chain from the pattern generator, strobes capture,
// and compacts the unloaded responses while the next pattern loads.
// Assumes: scan_out is the chain tail, updated by the same clock.
module bist_scan_seq
    import bist_seq_pkg::*;
#(
    parameter int               CHAIN_LEN = 8,
    parameter int               NUM_PAT   = 5,
    parameter int               GEN_W     = 8,
    parameter logic [GEN_W-1:0] GEN_TAPS  = 8'hB8,
    parameter logic [GEN_W-1:0] GEN_SEED  = 8'h5A,
    parameter int               SIG_W     = 16,
    parameter logic [SIG_W-1:0] SIG_TAPS  = 16'hB400,
    parameter logic [SIG_W-1:0] SIG_SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             scan_in,
    output logic             scan_en,
    output logic             capture,
    input  logic             scan_out,
    output logic [SIG_W-1:0] signature,
    output logic             done
);
    seq_state_e st;
    logic       gen_load, gen_step, sig_clear, sig_absorb, gen_bit;

    bist_seq_ctrl #(.CHAIN_LEN(CHAIN_LEN), .NUM_PAT(NUM_PAT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .state(st),
        .gen_load(gen_load), .gen_step(gen_step),
        .sig_clear(sig_clear), .sig_absorb(sig_absorb), .done(done)
    );

    bist_prpg #(.GEN_W(GEN_W), .GEN_TAPS(GEN_TAPS), .GEN_SEED(GEN_SEED)) u_prpg (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .step(gen_step),
        .serial_bit(gen_bit)
    );

    bist_sisr #(.SIG_W(SIG_W), .SIG_TAPS(SIG_TAPS), .SIG_SEED(SIG_SEED)) u_sisr (
        .clk(clk), .rst_n(rst_n), .clear(sig_clear), .absorb(sig_absorb),
        .sdi(scan_out), .sig(signature)
    );

    // Chain controls: shift during load and flush, zero fill while flushing.
    always_comb begin
        scan_en = (st == ST_SHIFT) || (st == ST_FLUSH);
        capture = (st == ST_CAPTURE);
        scan_in = (st == ST_SHIFT) && gen_bit;
    end
endmodule

// File: rtl/bist_seq_checker.sv
// Protocol checker for the sequencer; attached to every instance by bind.
module bist_seq_checker
    import bist_seq_pkg::*;
#(
    parameter int SIG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             scan_in,
    input logic             scan_en,
    input logic             capture,
    input logic [SIG_W-1:0] signature,
    input logic             done,
    input seq_state_e       st
);
    // R4: capture lasts one cycle.
    p_capture_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);

    // R4: capture and shift never overlap.
    p_capture_no_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !scan_en);

    // R6: flush feeds zeros.
    p_flush_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FLUSH) |-> !scan_in);

    // R7: done and signature hold until a start.
    p_done_holds_sig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(signature)));

    // R7: chain quiet while done.
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scan_en && !capture));

    // R2: accepted start opens a shift with done cleared.
    p_start_begins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && start) |=> (scan_en && !done));

    // R8: start while shifting does not return to idle.
    p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_SHIFT) && start) |=> (st != ST_IDLE));
endmodule

bind bist_scan_seq bist_seq_checker #(.SIG_W(SIG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_in(scan_in),
    .scan_en(scan_en), .capture(capture), .signature(signature),
    .done(done), .st(st)
);

// File: tb/tb_bist_scan_seq.sv
`timescale 1ns/1ps
module tb_bist_scan_seq;
    localparam int               L      = 8;
    localparam int               NP     = 5;
    localparam int               GW     = 8;
    localparam logic [GW-1:0]    GTAPS  = 8'hB8;
    localparam logic [GW-1:0]    GSEED  = 8'h5A;
    localparam int               SW     = 16;
    localparam logic [SW-1:0]    STAPS  = 16'hB400;
    localparam logic [SW-1:0]    SSEED  = 16'hACE1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          scan_in, scan_en, capture, scan_out, done;
    logic [SW-1:0] signature;
    logic [L-1:0]  chain = '0;
    logic [L-1:0]  cut_key = '0;
    int            n_chk = 0;
    int            n_bad = 0;

    always #4 clk = ~clk;

    bist_scan_seq #(
        .CHAIN_LEN(L), .NUM_PAT(NP), .GEN_W(GW), .GEN_TAPS(GTAPS), .GEN_SEED(GSEED),
        .SIG_W(SW), .SIG_TAPS(STAPS), .SIG_SEED(SSEED)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .scan_in(scan_in),
        .scan_en(scan_en), .capture(capture), .scan_out(scan_out),
        .signature(signature), .done(done)
    );

    // Circuit under test: rotate left and XOR a key.
    function automatic logic [L-1:0] cut_fn(input logic [L-1:0] x, input logic [L-1:0] k);
        return {x[L-2:0], x[L-1]} ^ k;
    endfunction

    // Scan chain model: head at L-1, tail at bit 0.
    always_ff @(posedge clk) begin
        if (scan_en)      chain <= {scan_in, chain[L-1:1]};
        else if (capture) chain <= cut_fn(chain, cut_key);
    end
    assign scan_out = chain[0];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [SW-1:0] sisr_step(input logic [SW-1:0] s, input logic b);
        return {s[SW-2:0], (^(s & STAPS)) ^ b};
    endfunction

    // One full run, checked cycle by cycle against the requirement model.
    task automatic run(input logic [L-1:0] key, input int inject_at);
        logic [GW-1:0] g = GSEED;
        logic [SW-1:0] s = SSEED;
        logic [L-1:0]  ch = '0;
        int            cyc = 0;
        cut_key = key;
        @(negedge clk); start = 1'b1;
        for (int p = 0; p < NP; p++) begin
            for (int i = 0; i < L; i++) begin
                @(negedge clk);
                start = (cyc == inject_at);
                cyc++;
                chk("R2/R4 scan_en in shift", 32'(scan_en), 32'd1);
                chk("R4 capture low in shift", 32'(capture), 32'd0);
                chk("R3 scan_in stream", 32'(scan_in), 32'(g[GW-1]));
                if (p == 0 && i == 0) chk("R2 done cleared", 32'(done), 32'd0);
                if (p > 0) s = sisr_step(s, ch[0]);
                ch = {g[GW-1], ch[L-1:1]};
                g  = {g[GW-2:0], ^(g & GTAPS)};
            end
            @(negedge clk);
            start = 1'b0;
            chk("R4 capture strobe", 32'(capture), 32'd1);
            chk("R4 scan_en low in capture", 32'(scan_en), 32'd0);
            ch = cut_fn(ch, key);
        end
        for (int i = 0; i < L; i++) begin
            @(negedge clk);
            chk("R6 flush scan_en", 32'(scan_en), 32'd1);
            chk("R6 flush zero fill", 32'(scan_in), 32'd0);
            s  = sisr_step(s, ch[0]);
            ch = {1'b0, ch[L-1:1]};
        end
        @(negedge clk);
        chk("R7 done rises", 32'(done), 32'd1);
        chk("R5 signature", 32'(signature), 32'(s));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 done held", 32'(done), 32'd1);
            chk("R7 signature stable", 32'(signature), 32'(s));
            chk("R7 chain quiet", 32'({scan_en, capture}), 32'd0);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 32'({scan_en, capture, scan_in, done}), 32'd0);
        chk("R1 reset signature", 32'(signature), 32'(SSEED));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 32'({scan_en, capture, done}), 32'd0);
        for (int k = 0; k < 16; k++) run(L'(k), -1);
        run(8'hA5, 12);
        run(8'h3C, -1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule